// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address of every beat in one SDRAM burst. A start pulse captures the first column along with the burst-length code and the ordering bit, both as held in the mode register. Each enabled cycle after that moves the output to the next column of the burst. A flag marks the final beat of a fixed-length burst. A stop pulse ends a burst early. If a new start pulse arrives in the middle of a burst, the sequence begins again from the new column.

Two orderings are supported. Sequential ordering counts the low column bits upward and wraps them inside an aligned block the size of the burst. Interleaved ordering XORs the start column with the beat index. Fixed lengths are 1, 2, 4 and 8 beats. In sequential mode, one code selects a full-page burst that walks all 256 columns of a row and runs until it is stopped or restarted. All outputs are registered. The column belonging to a start pulse or an advance appears in the cycle after the edge that samples it.

Top module: `burst_col_gen`

## Requirements
- R1: Length codes map to beat counts as follows: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `last` is high, together with `valid`, exactly while the final beat is presented. An advance during the final beat drops `valid` on the next cycle.
- R2: When `interleave`=0 and the length is fixed, beat k presents the start column with its low log2(length) bits replaced by (start+k) mod length. For example, length 4 from column 2 gives 2,3,0,1.
- R3: When `interleave`=1, beat k presents start XOR k. For example, length 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: During a fixed-length burst, the column bits above the burst block never change.
- R5: Code 3'b111 with `interleave`=0 selects a full-page burst. Beat k presents (start+k) mod 256. The burst continues past 256 beats, and `last` is never asserted.
- R6: The reserved codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `interleave`=1, all act as a burst of length 1.
- R7: A `stop` pulse without `start` makes `valid` and `last` low on the next cycle.
- R8: A `start` pulse takes priority over `stop` and `adv` and over any burst in progress. On the next cycle, `valid` is 1 and `col` equals the sampled `start_col`.
- R9: While `adv` is low, `col`, `valid` and `last` keep their values.
- R10: After reset, `valid`=0, `last`=0 and `col`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst-length code |
| interleave | input | 1 | Ordering: 0 sequential, 1 interleaved |
| adv | input | 1 | Move to the next beat |
| stop | input | 1 | End the burst now |
| col | output | 8 | Column of the current beat |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final one |

## Verification
The checker evaluates several rules on every cycle: a start loads its column, a stop or an advance past the final beat ends the burst, a stall holds the outputs, the bits above the burst block stay frozen, and a full-page burst never raises `last`. The exact orderings can only be shown by the bench's scenarios, which compare every beat against a model. These scenarios cover the wrap points in both modes, reserved and full-page codes, a full-page burst that runs across column 255, and restarts in the middle of a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W = 8;
  localparam int LG_W  = 2;

  typedef struct packed {
    logic [LG_W-1:0] lg;
    logic            fp;
    logic            il;
  } burst_cfg_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
(
  input  logic [2:0]  len_code,
  input  logic        interleave,
  output burst_cfg_t  cfg
);
  always_comb begin
    cfg.il = interleave;
    cfg.fp = 1'b0;
    cfg.lg = '0;
    if (!len_code[2]) begin
      cfg.lg = len_code[1:0];
    end else if (len_code == 3'b111 && !interleave) begin
      cfg.fp = 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc
  import burst_col_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] beat,
  input  burst_cfg_t   cfg,
  output logic [W-1:0] col,
  output logic [W-1:0] mask
);
  always_comb begin
    mask = (W'(1) << cfg.lg) - W'(1);
    if (cfg.fp)
      col = base + beat;
    else if (cfg.il)
      col = (base & ~mask) | ((base ^ beat) & mask);
    else
      col = (base & ~mask) | ((base + beat) & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_col,
  input  logic [2:0]   len_code,
  input  logic         interleave,
  input  logic         adv,
  input  logic         stop,
  output logic [W-1:0] col,
  output logic         valid,
  output logic         last
);
  burst_cfg_t   dec_cfg, cfg_q, cfg_n;
  logic [W-1:0] base_q, base_n, beat_q, beat_n, col_n, mask_n;
  logic         valid_n, last_n;

  burst_len_decode u_dec (
    .len_code  (len_code),
    .interleave(interleave),
    .cfg       (dec_cfg)
  );

  always_comb begin
    cfg_n   = cfg_q;
    base_n  = base_q;
    beat_n  = beat_q;
    valid_n = valid;
    if (start) begin
      cfg_n   = dec_cfg;
      base_n  = start_col;
      beat_n  = '0;
      valid_n = 1'b1;
    end else if (stop) begin
      valid_n = 1'b0;
    end else if (adv && valid) begin
      if (last) valid_n = 1'b0;
      else      beat_n  = beat_q + W'(1);
    end
  end

  burst_col_calc #(.W(W)) u_calc (
    .base(base_n),
    .beat(beat_n),
    .cfg (cfg_n),
    .col (col_n),
    .mask(mask_n)
  );

  assign last_n = valid_n && !cfg_n.fp && (beat_n == mask_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      base_q <= '0;
      beat_q <= '0;
      col    <= '0;
      valid  <= 1'b0;
      last   <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      base_q <= base_n;
      beat_q <= beat_n;
      col    <= col_n;
      valid  <= valid_n;
      last   <= last_n;
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] start_col,
  input logic         adv,
  input logic         stop,
  input logic [W-1:0] col,
  input logic         valid,
  input logic         last,
  input logic         fp_q,
  input logic [1:0]   lg_q
);
  logic [W-1:0] blk_mask;
  assign blk_mask = (W'(1) << lg_q) - W'(1);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst) start |=> valid && col == $past(start_col)); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst) stop && !start |=> !valid && !last); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst) last && adv && !start && !stop |=> !valid); // R1
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) last |-> valid); // R1
  AST_FP_NO_LAST: assert property (@(posedge clk) disable iff (rst) valid && fp_q |-> !last); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) valid && !adv && !start && !stop |=> valid && $stable(col) && $stable(last)); // R9
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst) valid && $past(valid) && !$past(start) && !fp_q |-> ((col ^ $past(col)) & ~blk_mask) == '0); // R4
endmodule

bind burst_col_gen burst_col_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_col(start_col),
  .adv(adv), .stop(stop), .col(col), .valid(valid), .last(last),
  .fp_q(cfg_q.fp), .lg_q(cfg_q.lg)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst = 1;
  logic       start = 0, interleave = 0, adv = 0, stop = 0;
  logic [7:0] start_col = 0;
  logic [2:0] len_code = 0;
  logic [7:0] col;
  logic       valid, last;

  int n_run = 0, n_fail = 0;

  bit         m_valid = 0, m_fp = 0, m_il = 0;
  int         m_len = 1, m_beat = 0;
  logic [7:0] m_base = 0;

  burst_col_gen u_dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .adv(adv), .stop(stop),
    .col(col), .valid(valid), .last(last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_len(input logic [2:0] c, input bit il);
    if (!c[2]) return 1 << c[1:0];
    if (c == 3'b111 && !il) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] ref_col(input logic [7:0] b, input int k, input int len, input bit il);
    logic [7:0] m;
    if (len == 0) return 8'(int'(b) + k);
    m = 8'(len - 1);
    if (il) return b ^ 8'(k);
    return (b & ~m) | (8'(int'(b) + k) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit s, input logic [7:0] sc, input logic [2:0] lc,
                     input bit il, input bit a, input bit st);
    bit exp_last;
    start = s; start_col = sc; len_code = lc; interleave = il; adv = a; stop = st;
    if (s) begin
      m_valid = 1; m_beat = 0; m_base = sc; m_len = ref_len(lc, il); m_fp = (m_len == 0); m_il = il;
    end else if (st) begin
      m_valid = 0;
    end else if (a && m_valid) begin
      if (!m_fp && m_beat == m_len - 1) m_valid = 0;
      else m_beat = m_beat + 1;
    end
    @(posedge clk);
    @(negedge clk);
    exp_last = m_valid && !m_fp && (m_beat == m_len - 1);
    chk({tag, " valid"}, 32'(valid), 32'(m_valid));
    chk({tag, " last"}, 32'(last), 32'(exp_last));
    if (m_valid) chk({tag, " col"}, 32'(col), 32'(ref_col(m_base, m_beat, m_len, m_il)));
    start = 0; adv = 0; stop = 0;
  endtask

  task automatic run_burst(input string tag, input logic [7:0] sc, input logic [2:0] lc,
                           input bit il, input int beats);
    cyc(tag, 1, sc, lc, il, 0, 0);
    for (int i = 0; i < beats; i++) cyc(tag, 0, 0, lc, il, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R10 valid", 32'(valid), 0);
    chk("R10 last", 32'(last), 0);
    chk("R10 col", 32'(col), 0);

    run_burst("R1 len1", 8'h33, 3'b000, 0, 1);
    run_burst("R1 len2", 8'h37, 3'b001, 0, 2);
    run_burst("R2 len4 s2", 8'h02, 3'b010, 0, 4);
    run_burst("R2 len8 s6", 8'h16, 3'b011, 0, 8);
    run_burst("R3 len8 s5", 8'h05, 3'b011, 1, 8);
    run_burst("R3 len4 s3", 8'hA3, 3'b010, 1, 4);
    run_burst("R4 len8 s4E", 8'h4E, 3'b011, 0, 8);
    run_burst("R4 il s4F", 8'h4F, 3'b011, 1, 8);
    run_burst("R5 fullpage", 8'hFD, 3'b111, 0, 300);
    cyc("R5 stop", 0, 0, 0, 0, 0, 1);
    run_burst("R6 rsv100", 8'h12, 3'b100, 0, 2);
    run_burst("R6 rsv101", 8'h13, 3'b101, 1, 2);
    run_burst("R6 rsv110", 8'h14, 3'b110, 0, 2);
    run_burst("R6 fp il", 8'h15, 3'b111, 1, 2);

    cyc("R7", 1, 8'h20, 3'b011, 0, 0, 0);
    cyc("R7", 0, 0, 3'b011, 0, 1, 0);
    cyc("R7 stop", 0, 0, 3'b011, 0, 1, 1);
    cyc("R7 idle", 0, 0, 3'b011, 0, 1, 0);

    cyc("R8", 1, 8'h40, 3'b011, 0, 0, 0);
    cyc("R8", 0, 0, 3'b011, 0, 1, 0);
    cyc("R8 restart", 1, 8'h9A, 3'b010, 1, 1, 1);
    for (int i = 0; i < 4; i++) cyc("R8 after", 0, 0, 0, 0, 1, 0);

    cyc("R9", 1, 8'h61, 3'b011, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R9 hold", 0, 0, 3'b011, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc("R9 resume", 0, 0, 3'b011, 0, 1, 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit s, a, st, il;
      logic [2:0] lc;
      string tag;
      s  = ($urandom % 12) == 0;
      st = ($urandom % 40) == 0;
      a  = ($urandom % 4) != 0;
      il = $urandom % 2;
      lc = 3'($urandom);
      if (m_fp) tag = "R5 rand";
      else if (m_il) tag = "R3 rand";
      else tag = "R2 rand";
      cyc(tag, s, 8'($urandom), lc, il, a, st);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule